// File: doc/BRIEF.md
# Segmented Linear Address Generator

This block forms the linear address of one memory reference for a processor with six 16-bit segment registers. Each request gives a reference kind, an optional base register (its number and value), an optional index value with a scale code, a displacement with a size code, an optional segment-override selector and a mode bit. The block picks the segment, computes the effective offset, adds the segment base and registers the result one cycle later with a valid flag.

The segment is fixed for instruction fetches, stack pushes and pops, and string destinations, and any override is ignored for them. General data references default to the stack segment when the base register is the stack or frame pointer, and to the data segment otherwise; an override replaces that default. In real mode the address is the segment shifted left by four plus a 16-bit offset, kept to 20 bits. In flat 64-bit mode four of the segment bases read as zero, and the two extra segments still contribute their base. Segment registers are loaded through a separate write port.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset every segment register is zero, `lin_valid` is 0 and `lin_addr` is 0.
- R2: When `seg_wr_en` is 1, the register named by `seg_wr_sel` takes `seg_wr_val` at the next rising edge (codes: 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS); codes 6 and 7 change no register. A request in the same cycle as a write still sees the old value.
- R3: A reference of kind 0 (instruction fetch) selects CS (`seg_sel` = 1) whatever `ovr_en` and `ovr_sel` are.
- R4: A reference of kind 1 (stack push or pop) selects SS (`seg_sel` = 2) whatever the override inputs are.
- R5: A reference of kind 3 (string destination) selects ES (`seg_sel` = 0) whatever the override inputs are.
- R6: A reference of kind 2 (general data) with no usable override selects SS when `base_en` is 1 and `base_num` is 4 (stack pointer) or 5 (frame pointer), and DS otherwise; the index inputs never influence the choice.
- R7: For kind 2, `ovr_en` = 1 with `ovr_sel` in 0..5 selects that segment; `ovr_sel` values 6 and 7 are ignored and the default of R6 applies.
- R8: `eff_off` = base (if `base_en`) + (index << `scale_code`) (if `index_en`) + displacement sign-extended from 8, 16 or 32 bits for `disp_size` 1, 2, 3 (0 means no displacement), modulo 2^64 when `flat_mode` = 1 and reduced to its low 16 bits when `flat_mode` = 0.
- R9: In real mode (`flat_mode` = 0) the registered `lin_addr` is (segment × 16 + `eff_off`) modulo 2^20, with bits 63..20 zero.
- R10: In flat mode (`flat_mode` = 1) `lin_addr` equals `eff_off` for ES, CS, SS and DS, and equals (FS or GS value × 16 + `eff_off`) modulo 2^64 for FS and GS.
- R11: `lin_valid` is 1 exactly in the cycle after a cycle with `req_valid` = 1; `lin_addr` keeps its value through cycles with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_wr_en | input | 1 | Segment register load enable |
| seg_wr_sel | input | 3 | Segment register to load |
| seg_wr_val | input | 16 | Value to load |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | Reference kind: 0 fetch, 1 stack, 2 data, 3 string destination |
| base_en | input | 1 | Base register used |
| base_num | input | 4 | Base register number |
| base_val | input | 64 | Base register value |
| index_en | input | 1 | Index register used |
| index_val | input | 64 | Index register value |
| scale_code | input | 2 | Index scale: 1, 2, 4, 8 for codes 0..3 |
| disp | input | 32 | Displacement bits |
| disp_size | input | 2 | 0 none, 1 8-bit, 2 16-bit, 3 32-bit |
| ovr_en | input | 1 | Segment-override prefix present |
| ovr_sel | input | 3 | Override segment code |
| flat_mode | input | 1 | 0 real mode, 1 flat 64-bit mode |
| seg_sel | output | 3 | Chosen segment code (combinational) |
| eff_off | output | 64 | Effective offset (combinational) |
| lin_valid | output | 1 | Registered linear address valid |
| lin_addr | output | 64 | Registered linear address |

## Verification
The embedded assertions watch, on every cycle, that fetches, stack operations and string destinations never leave their fixed segment, that the valid flag trails the request by one cycle, that the address holds when idle, that loads land in the named register and reserved load codes touch nothing, and that real-mode results never set a bit above bit 19. Only the bench scenarios can show the arithmetic: scale codes, sign extension of each displacement size, both wrap-arounds, the stack-pointer and frame-pointer defaults, the handling of reserved override codes, and the split between zeroed and kept bases in flat mode.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

   localparam int SEG_COUNT = 6;
   localparam int SEG_ID_W  = 3;
   localparam int DISP_W    = 32;

   typedef enum logic [SEG_ID_W-1:0] {
      SEG_ES = 3'd0,
      SEG_CS = 3'd1,
      SEG_SS = 3'd2,
      SEG_DS = 3'd3,
      SEG_FS = 3'd4,
      SEG_GS = 3'd5
   } seg_id_e;

   typedef enum logic [1:0] {
      REF_FETCH  = 2'd0,
      REF_STACK  = 2'd1,
      REF_DATA   = 2'd2,
      REF_STRDST = 2'd3
   } ref_kind_e;

   typedef enum logic [1:0] {
      DSZ_NONE = 2'd0,
      DSZ_8    = 2'd1,
      DSZ_16   = 2'd2,
      DSZ_32   = 2'd3
   } disp_size_e;

endpackage

// File: rtl/seg_reg_file.sv
module seg_reg_file
   import seg_addr_pkg::*;
#(
   parameter int SEG_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [SEG_ID_W-1:0] wr_sel,
   input  logic [SEG_W-1:0]    wr_val,
   input  logic [SEG_ID_W-1:0] rd_sel,
   output logic [SEG_W-1:0]    rd_val
);

   logic [SEG_COUNT-1:0][SEG_W-1:0] regs_q;

   generate
      for (genvar g = 0; g < SEG_COUNT; g++) begin : g_seg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               regs_q[g] <= '0;
            end else if (wr_en && (wr_sel == SEG_ID_W'(g))) begin
               regs_q[g] <= wr_val;
            end
         end

         // R2
         seg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_sel == SEG_ID_W'(g))) |=> (regs_q[g] == $past(wr_val)));
      end
   endgenerate

   always_comb begin
      rd_val = '0;
      for (int i = 0; i < SEG_COUNT; i++) begin
         if (rd_sel == SEG_ID_W'(i)) rd_val = regs_q[i];
      end
   end

   // R2
   seg_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || (int'(wr_sel) >= SEG_COUNT)) |=> $stable(regs_q));

endmodule

// File: rtl/seg_select.sv
module seg_select
   import seg_addr_pkg::*;
#(
   parameter int REG_NUM_W = 4,
   parameter int SP_NUM    = 4,
   parameter int BP_NUM    = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [1:0]           kind,
   input  logic                 base_en,
   input  logic [REG_NUM_W-1:0] base_num,
   input  logic                 ovr_en,
   input  logic [SEG_ID_W-1:0]  ovr_sel,
   output logic [SEG_ID_W-1:0]  seg_id
);

   logic    stack_base;
   logic    ovr_ok;
   seg_id_e data_dflt;
   seg_id_e pick;

   assign stack_base = base_en &&
                       ((base_num == REG_NUM_W'(SP_NUM)) || (base_num == REG_NUM_W'(BP_NUM)));
   assign ovr_ok     = ovr_en && (int'(ovr_sel) < SEG_COUNT);
   assign data_dflt  = stack_base ? SEG_SS : SEG_DS;

   always_comb begin
      unique case (ref_kind_e'(kind))
         REF_FETCH:  pick = SEG_CS;
         REF_STACK:  pick = SEG_SS;
         REF_STRDST: pick = SEG_ES;
         default:    pick = ovr_ok ? seg_id_e'(ovr_sel) : data_dflt;
      endcase
   end

   assign seg_id = pick;

   // R3
   fetch_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (kind == 2'd0)) |-> (seg_id == 3'd1));

   // R4
   stack_ss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (kind == 2'd1)) |-> (seg_id == 3'd2));

   // R5
   strdst_es_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (kind == 2'd3)) |-> (seg_id == 3'd0));

   // R7
   seg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (int'(seg_id) < SEG_COUNT));

endmodule

// File: rtl/ea_calc.sv
module ea_calc
   import seg_addr_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int REAL_OFF_W = 16
) (
   input  logic              base_en,
   input  logic [ADDR_W-1:0] base_val,
   input  logic              index_en,
   input  logic [ADDR_W-1:0] index_val,
   input  logic [1:0]        scale_code,
   input  logic [DISP_W-1:0] disp,
   input  logic [1:0]        disp_size,
   input  logic              flat_mode,
   output logic [ADDR_W-1:0] eff_off
);

   localparam logic [ADDR_W-1:0] REAL_MASK =
      {{(ADDR_W-REAL_OFF_W){1'b0}}, {REAL_OFF_W{1'b1}}};

   logic [ADDR_W-1:0] base_term;
   logic [ADDR_W-1:0] index_term;
   logic [ADDR_W-1:0] disp_term;
   logic [ADDR_W-1:0] sum;

   always_comb begin
      unique case (disp_size_e'(disp_size))
         DSZ_8:   disp_term = {{(ADDR_W-8){disp[7]}}, disp[7:0]};
         DSZ_16:  disp_term = {{(ADDR_W-16){disp[15]}}, disp[15:0]};
         DSZ_32:  disp_term = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
         default: disp_term = '0;
      endcase
   end

   assign base_term  = base_en  ? base_val : '0;
   assign index_term = index_en ? (index_val << scale_code) : '0;
   assign sum        = base_term + index_term + disp_term;
   assign eff_off    = flat_mode ? sum : (sum & REAL_MASK);

endmodule

// File: rtl/lin_stage.sv
module lin_stage
   import seg_addr_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int SEG_W      = 16,
   parameter int REAL_LIN_W = 20
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                flat_mode,
   input  logic [SEG_ID_W-1:0] seg_id,
   input  logic [SEG_W-1:0]    seg_val,
   input  logic [ADDR_W-1:0]   eff_off,
   output logic                lin_valid,
   output logic [ADDR_W-1:0]   lin_addr
);

   localparam int SHIFT = REAL_LIN_W - SEG_W;
   localparam logic [ADDR_W-1:0] REAL_MASK =
      {{(ADDR_W-REAL_LIN_W){1'b0}}, {REAL_LIN_W{1'b1}}};

   logic              keeps_base;
   logic [ADDR_W-1:0] seg_base;
   logic [ADDR_W-1:0] sum;
   logic [ADDR_W-1:0] next_addr;

   assign keeps_base = (seg_id_e'(seg_id) == SEG_FS) || (seg_id_e'(seg_id) == SEG_GS);
   assign seg_base   = (flat_mode && !keeps_base) ? '0
                       : {{(ADDR_W-REAL_LIN_W){1'b0}}, seg_val, {SHIFT{1'b0}}};
   assign sum        = seg_base + eff_off;
   assign next_addr  = flat_mode ? sum : (sum & REAL_MASK);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lin_valid <= 1'b0;
         lin_addr  <= '0;
      end else begin
         lin_valid <= req_valid;
         if (req_valid) lin_addr <= next_addr;
      end
   end

   // R11
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> lin_valid);

   // R11
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!lin_valid && $stable(lin_addr)));

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
   import seg_addr_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int SEG_W      = 16,
   parameter int REG_NUM_W  = 4,
   parameter int SP_NUM     = 4,
   parameter int BP_NUM     = 5,
   parameter int REAL_LIN_W = 20,
   parameter int REAL_OFF_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 seg_wr_en,
   input  logic [2:0]           seg_wr_sel,
   input  logic [SEG_W-1:0]     seg_wr_val,
   input  logic                 req_valid,
   input  logic [1:0]           req_kind,
   input  logic                 base_en,
   input  logic [REG_NUM_W-1:0] base_num,
   input  logic [ADDR_W-1:0]    base_val,
   input  logic                 index_en,
   input  logic [ADDR_W-1:0]    index_val,
   input  logic [1:0]           scale_code,
   input  logic [31:0]          disp,
   input  logic [1:0]           disp_size,
   input  logic                 ovr_en,
   input  logic [2:0]           ovr_sel,
   input  logic                 flat_mode,
   output logic [2:0]           seg_sel,
   output logic [ADDR_W-1:0]    eff_off,
   output logic                 lin_valid,
   output logic [ADDR_W-1:0]    lin_addr
);

   generate
      if (REAL_LIN_W <= SEG_W) begin : g_bad_shift
         $error("REAL_LIN_W must exceed SEG_W");
      end
      if (ADDR_W < DISP_W || ADDR_W <= REAL_LIN_W) begin : g_bad_addr
         $error("ADDR_W too narrow for displacement or real-mode address");
      end
      if (REAL_OFF_W > REAL_LIN_W) begin : g_bad_off
         $error("REAL_OFF_W must not exceed REAL_LIN_W");
      end
      if (SP_NUM >= (1 << REG_NUM_W) || BP_NUM >= (1 << REG_NUM_W)) begin : g_bad_num
         $error("pointer register numbers do not fit REG_NUM_W");
      end
   endgenerate

   logic [SEG_ID_W-1:0] seg_id;
   logic [SEG_W-1:0]    seg_val;

   seg_select #(
      .REG_NUM_W (REG_NUM_W),
      .SP_NUM    (SP_NUM),
      .BP_NUM    (BP_NUM)
   ) u_select (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .kind      (req_kind),
      .base_en   (base_en),
      .base_num  (base_num),
      .ovr_en    (ovr_en),
      .ovr_sel   (ovr_sel),
      .seg_id    (seg_id)
   );

   seg_reg_file #(
      .SEG_W (SEG_W)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (seg_wr_en),
      .wr_sel (seg_wr_sel),
      .wr_val (seg_wr_val),
      .rd_sel (seg_id),
      .rd_val (seg_val)
   );

   ea_calc #(
      .ADDR_W     (ADDR_W),
      .REAL_OFF_W (REAL_OFF_W)
   ) u_ea (
      .base_en    (base_en),
      .base_val   (base_val),
      .index_en   (index_en),
      .index_val  (index_val),
      .scale_code (scale_code),
      .disp       (disp),
      .disp_size  (disp_size),
      .flat_mode  (flat_mode),
      .eff_off    (eff_off)
   );

   lin_stage #(
      .ADDR_W     (ADDR_W),
      .SEG_W      (SEG_W),
      .REAL_LIN_W (REAL_LIN_W)
   ) u_lin (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .flat_mode (flat_mode),
      .seg_id    (seg_id),
      .seg_val   (seg_val),
      .eff_off   (eff_off),
      .lin_valid (lin_valid),
      .lin_addr  (lin_addr)
   );

   assign seg_sel = seg_id;

   // R9
   real_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lin_valid && !$past(flat_mode)) |-> (lin_addr[ADDR_W-1:REAL_LIN_W] == '0));

   // R8
   real_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !flat_mode) |-> (eff_off[ADDR_W-1:REAL_OFF_W] == '0));

endmodule

// File: tb/seg_addr_gen_bench.sv
`timescale 1ns/1ps
module seg_addr_gen_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        seg_wr_en = 1'b0;
   logic [2:0]  seg_wr_sel = '0;
   logic [15:0] seg_wr_val = '0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = '0;
   logic        base_en = 1'b0;
   logic [3:0]  base_num = '0;
   logic [63:0] base_val = '0;
   logic        index_en = 1'b0;
   logic [63:0] index_val = '0;
   logic [1:0]  scale_code = '0;
   logic [31:0] disp = '0;
   logic [1:0]  disp_size = '0;
   logic        ovr_en = 1'b0;
   logic [2:0]  ovr_sel = '0;
   logic        flat_mode = 1'b0;
   logic [2:0]  seg_sel;
   logic [63:0] eff_off;
   logic        lin_valid;
   logic [63:0] lin_addr;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [15:0] model_seg [6];
   logic [63:0] held_addr;

   always #2 clk = ~clk;

   seg_addr_gen u_seg_addr_gen (
      .clk(clk), .rst_n(rst_n), .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel),
      .seg_wr_val(seg_wr_val), .req_valid(req_valid), .req_kind(req_kind),
      .base_en(base_en), .base_num(base_num), .base_val(base_val),
      .index_en(index_en), .index_val(index_val), .scale_code(scale_code),
      .disp(disp), .disp_size(disp_size), .ovr_en(ovr_en), .ovr_sel(ovr_sel),
      .flat_mode(flat_mode), .seg_sel(seg_sel), .eff_off(eff_off),
      .lin_valid(lin_valid), .lin_addr(lin_addr)
   );

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic load_seg(input logic [2:0] sel, input logic [15:0] val);
      @(negedge clk);
      seg_wr_en = 1'b1; seg_wr_sel = sel; seg_wr_val = val;
      @(negedge clk);
      seg_wr_en = 1'b0;
      if (sel < 3'd6) model_seg[sel] = val;
   endtask

   // Reference: segment choice, offset and linear address from the requirements
   task automatic do_req(input string req, input logic [1:0] kind,
                         input logic ben, input logic [3:0] bnum, input logic [63:0] bval,
                         input logic ien, input logic [63:0] ival, input logic [1:0] sc,
                         input logic [31:0] d, input logic [1:0] dsz,
                         input logic oen, input logic [2:0] osel, input logic flat);
      int exp_seg;
      logic [63:0] off, dext, lin;
      if (kind == 2'd0) exp_seg = 1;
      else if (kind == 2'd1) exp_seg = 2;
      else if (kind == 2'd3) exp_seg = 0;
      else if (oen && osel < 3'd6) exp_seg = int'(osel);
      else if (ben && (bnum == 4'd4 || bnum == 4'd5)) exp_seg = 2;
      else exp_seg = 3;
      case (dsz)
         2'd1: dext = 64'(signed'(d[7:0]));
         2'd2: dext = 64'(signed'(d[15:0]));
         2'd3: dext = 64'(signed'(d));
         default: dext = 0;
      endcase
      off = (ben ? bval : 64'd0) + (ien ? ival * (64'd1 << sc) : 64'd0) + dext;
      if (!flat) begin
         off = off % 64'h1_0000;
         lin = ((64'(model_seg[exp_seg]) * 16) + off) % 64'h10_0000;
      end else if (exp_seg >= 4) begin
         lin = (64'(model_seg[exp_seg]) * 16) + off;
      end else begin
         lin = off;
      end
      @(negedge clk);
      req_valid = 1'b1; req_kind = kind; base_en = ben; base_num = bnum; base_val = bval;
      index_en = ien; index_val = ival; scale_code = sc; disp = d; disp_size = dsz;
      ovr_en = oen; ovr_sel = osel; flat_mode = flat;
      #1;
      check(req, "seg_sel", 64'(seg_sel), 64'(exp_seg));
      check(req, "eff_off", eff_off, off);
      @(posedge clk);
      #1;
      check("R11", "lin_valid", 64'(lin_valid), 64'd1);
      check(req, "lin_addr", lin_addr, lin);
      held_addr = lin;
   endtask

   task automatic idle_cycle();
      @(negedge clk);
      req_valid = 1'b0;
      ovr_en = 1'b1; ovr_sel = 3'd5;
      @(posedge clk);
      #1;
      check("R11", "idle lin_valid", 64'(lin_valid), 64'd0);
      check("R11", "idle lin_addr hold", lin_addr, held_addr);
   endtask

   initial begin
      for (int i = 0; i < 6; i++) model_seg[i] = '0;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check("R1", "lin_valid", 64'(lin_valid), 64'd0);
      check("R1", "lin_addr", lin_addr, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: segments read as zero right after reset
      do_req("R1", 2'd2, 1'b1, 4'd3, 64'h1234, 1'b0, 0, 2'd0, 0, 2'd0, 1'b0, 3'd0, 1'b0);

      // R2: loads, including reserved codes
      load_seg(3'd0, 16'h1000);
      load_seg(3'd1, 16'h2000);
      load_seg(3'd2, 16'h3000);
      load_seg(3'd3, 16'h4000);
      load_seg(3'd4, 16'h5000);
      load_seg(3'd5, 16'h6000);
      load_seg(3'd6, 16'hDEAD);
      load_seg(3'd7, 16'hBEEF);
      for (int s = 0; s < 6; s++)
         do_req("R2", 2'd2, 1'b0, 4'd0, 0, 1'b0, 0, 2'd0, 32'h10, 2'd1, 1'b1, 3'(s), 1'b0);

      // R3/R4/R5: fixed segments, override ignored
      do_req("R3", 2'd0, 1'b1, 4'd0, 64'h100, 1'b0, 0, 2'd0, 0, 2'd0, 1'b1, 3'd4, 1'b0);
      do_req("R4", 2'd1, 1'b1, 4'd4, 64'hFFF0, 1'b0, 0, 2'd0, 0, 2'd0, 1'b1, 3'd3, 1'b0);
      do_req("R5", 2'd3, 1'b1, 4'd7, 64'h20, 1'b0, 0, 2'd0, 0, 2'd0, 1'b1, 3'd5, 1'b0);

      // R6: data defaults
      do_req("R6", 2'd2, 1'b1, 4'd4, 64'h40, 1'b0, 0, 2'd0, 0, 2'd0, 1'b0, 3'd0, 1'b0);
      do_req("R6", 2'd2, 1'b1, 4'd5, 64'h40, 1'b0, 0, 2'd0, 0, 2'd0, 1'b0, 3'd0, 1'b0);
      do_req("R6", 2'd2, 1'b1, 4'd6, 64'h40, 1'b1, 64'h4, 2'd1, 0, 2'd0, 1'b0, 3'd0, 1'b0);
      do_req("R6", 2'd2, 1'b0, 4'd4, 64'h40, 1'b1, 64'h4, 2'd0, 0, 2'd0, 1'b0, 3'd0, 1'b0);

      // R7: overrides, reserved codes fall back
      do_req("R7", 2'd2, 1'b1, 4'd5, 64'h8, 1'b0, 0, 2'd0, 0, 2'd0, 1'b1, 3'd0, 1'b0);
      do_req("R7", 2'd2, 1'b1, 4'd5, 64'h8, 1'b0, 0, 2'd0, 0, 2'd0, 1'b1, 3'd6, 1'b0);
      do_req("R7", 2'd2, 1'b1, 4'd1, 64'h8, 1'b0, 0, 2'd0, 0, 2'd0, 1'b1, 3'd7, 1'b0);
      idle_cycle();

      // R8: scales and displacement sizes
      for (int sc = 0; sc < 4; sc++)
         do_req("R8", 2'd2, 1'b1, 4'd1, 64'h1000, 1'b1, 64'h33, 2'(sc), 32'h0, 2'd0, 1'b0, 3'd0, 1'b1);
      do_req("R8", 2'd2, 1'b1, 4'd1, 64'h1000, 1'b0, 0, 2'd0, 32'hFFFF_FF80, 2'd1, 1'b0, 3'd0, 1'b1);
      do_req("R8", 2'd2, 1'b1, 4'd1, 64'h1000, 1'b0, 0, 2'd0, 32'h0001_8000, 2'd2, 1'b0, 3'd0, 1'b1);
      do_req("R8", 2'd2, 1'b1, 4'd1, 64'h1000, 1'b0, 0, 2'd0, 32'h8000_0000, 2'd3, 1'b0, 3'd0, 1'b1);
      do_req("R8", 2'd2, 1'b1, 4'd1, 64'h1000, 1'b0, 0, 2'd0, 32'h7F, 2'd0, 1'b0, 3'd0, 1'b1);
      do_req("R8", 2'd2, 1'b1, 4'd1, 64'h1_2345, 1'b1, 64'h1, 2'd3, 32'h7F, 2'd1, 1'b0, 3'd0, 1'b0);

      // R9: real-mode wrap at 2^20
      load_seg(3'd3, 16'hFFFF);
      do_req("R9", 2'd2, 1'b1, 4'd1, 64'hFFFF, 1'b0, 0, 2'd0, 0, 2'd0, 1'b0, 3'd0, 1'b0);
      do_req("R9", 2'd0, 1'b1, 4'd1, 64'hFFF0, 1'b0, 0, 2'd0, 32'h20, 2'd1, 1'b0, 3'd0, 1'b0);

      // R10: flat mode bases
      for (int s = 0; s < 6; s++)
         do_req("R10", 2'd2, 1'b1, 4'd1, 64'hABCD_0000_1234, 1'b0, 0, 2'd0, 0, 2'd0, 1'b1, 3'(s), 1'b1);
      do_req("R10", 2'd2, 1'b1, 4'd1, 64'hFFFF_FFFF_FFFF_FFF0, 1'b0, 0, 2'd0, 0, 2'd0, 1'b1, 3'd5, 1'b1);
      do_req("R10", 2'd2, 1'b1, 4'd1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 0, 2'd0, 32'h2, 2'd1, 1'b0, 3'd0, 1'b1);
      idle_cycle();
      idle_cycle();

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule